// File: doc/BRIEF.md
# NAND Operation Completion Monitor

This block waits for a NAND flash operation, such as a page program or a block erase, to finish, and then reports how it ended. A command sequencer starts it with a one-cycle pulse once the operation command has gone out. The monitor first waits a fixed write-to-busy settling interval. It then watches for completion in one of two ways. If the board wires the ready/busy line, the monitor waits for that line to go high. If not, it asks an external byte reader for status bytes over and over until the ready bit appears. A millisecond-scaled timer bounds the whole wait.

Whether the operation completed or timed out, the monitor always fetches one last status byte and returns it. With that byte it raises a timeout flag and a warning flag. The warning flag is set when the final byte does not show the ready bit. This catches a real timeout and also a ready/busy line that reports ready too early. The ready bit is bit 6 of the status byte (mask 40h).

The controller runs through six named states. IDLE goes to TWB on an accepted start. TWB goes to PIN when the pin is present, or to POLL when it is absent, after TWB_CYC cycles. PIN goes to FINAL when the synchronised pin is high or the timer expires. POLL goes back to POLL on a busy reply before expiry. POLL goes to FINAL on a ready reply, or on a busy reply after expiry. FINAL goes to DONE on the reader's acknowledge. DONE goes to IDLE unconditionally.

Top module: `nand_rdy_wait_mon`

## Requirements
- R1: Out of reset, st_req_o, done_o, timeout_o and warn_o are 0 and status_o is 00h.
- R2: After an accepted start, no status request is raised for TWB_CYC cycles. In status-poll mode the first request rises exactly TWB_CYC+1 cycles after the start pulse is sampled.
- R3: In pin mode (use_pin_i=1), once the synchronised rb_i is high, exactly one status read is made, with st_cmd_o=1 so that the reader issues the STATUS command first. Its byte is returned with timeout_o=0.
- R4: In poll mode (use_pin_i=0), rb_i has no effect. Only the first request carries st_cmd_o=1. Polling continues while bit 6 of the reply is 0. After the first reply with bit 6 set, exactly one more read is made, and that byte is returned.
- R5: If completion has not been seen within CYC_PER_MS*TIMEOUT_MS cycles of the start, timeout_o=1 is reported. In pin mode this happens when rb_i is still low. A final status read is still made, and its byte is returned.
- R6: warn_o equals the inverse of bit 6 of the returned status byte. This covers both a timeout and a ready/busy line that rose while the device was still busy.
- R7: done_o is a one-cycle pulse. status_o, timeout_o and warn_o change only in the cycle done_o is high, and hold until the next one.
- R8: A start pulse while an operation is in progress, up to and including the done cycle, is ignored. It produces no extra request and no extra done.
- R9: Once raised, st_req_o and st_cmd_o hold steady until the cycle st_ack_i is high. st_data_i is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: begin waiting for the current operation |
| use_pin_i | input | 1 | 1: ready/busy line is wired; 0: poll the status byte |
| rb_i | input | 1 | Ready/busy line from the device, high means ready (asynchronous) |
| st_req_o | output | 1 | Request one status byte from the byte reader |
| st_cmd_o | output | 1 | With st_req_o: issue the STATUS command before reading the byte |
| st_ack_i | input | 1 | Byte reader acknowledge, st_data_i valid |
| st_data_i | input | 8 | Status byte returned by the reader |
| done_o | output | 1 | One-cycle pulse: result outputs updated |
| status_o | output | 8 | Final status byte |
| timeout_o | output | 1 | Completion was not seen before the time limit |
| warn_o | output | 1 | Final status byte lacks the ready bit |

## Verification
Pin mode is tried with four pin patterns. A late rise separates normal completion from timeout. A line that is high from the start but paired with a busy status byte exposes the warning path without a timeout. A line that stays low is run twice, once with a final byte that shows ready and once with one that does not, which separates timeout_o from warn_o. Poll mode is tried with an immediately ready device, with a device that turns ready after three polls (and a high pin, showing the pin is ignored), and with a device that never turns ready; these distinguish the number of reads, the STATUS-command flag placement and the timeout path. A second start in the middle of an operation and a pin rise shortly before the limit cover start rejection and the timeout boundary.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TWB,
        S_PIN,
        S_POLL,
        S_FINAL,
        S_DONE
    } nrw_state_e;

    localparam int STAT_RDY_BIT = 6;

    function automatic logic stat_ready(input logic [7:0] b);
        return b[STAT_RDY_BIT];
    endfunction

endpackage

// File: rtl/nrw_twb_delay.sv
module nrw_twb_delay #(
    parameter int N = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int W = (N > 1) ? $clog2(N + 1) : 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= W'(N - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/nrw_timeout.sv
module nrw_timeout #(
    parameter int CYC_PER_MS = 250000,
    parameter int LIMIT_MS   = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic expired_o
);
    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int MW = $clog2(LIMIT_MS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);
    localparam logic [MW-1:0] MS_LAST  = MW'(LIMIT_MS);

    logic [PW-1:0] pre_q;
    logic [MW-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (en_i && !expired_o) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired_o = (ms_q == MS_LAST);

endmodule

// File: rtl/nand_rdy_wait_mon.sv
module nand_rdy_wait_mon
    import nrw_pkg::*;
#(
    parameter int CYC_PER_MS  = 250000,
    parameter int TIMEOUT_MS  = 400,
    parameter int TWB_CYC     = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       use_pin_i,
    input  logic       rb_i,
    output logic       st_req_o,
    output logic       st_cmd_o,
    input  logic       st_ack_i,
    input  logic [7:0] st_data_i,
    output logic       done_o,
    output logic [7:0] status_o,
    output logic       timeout_o,
    output logic       warn_o
);
    nrw_state_e state_q, state_d;

    logic [SYNC_STAGES-1:0] rb_sh;
    logic rb_s;
    logic use_pin_q;
    logic cmd_q;
    logic to_q;
    logic accept;
    logic twb_done;
    logic expired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_sh <= '0;
        else        rb_sh <= {rb_sh[SYNC_STAGES-2:0], rb_i};
    end
    assign rb_s = rb_sh[SYNC_STAGES-1];

    assign accept = (state_q == S_IDLE) && start_i;

    nrw_twb_delay #(.N(TWB_CYC)) u_twb (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .done_o (twb_done)
    );

    nrw_timeout #(.CYC_PER_MS(CYC_PER_MS), .LIMIT_MS(TIMEOUT_MS)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .en_i      (state_q != S_IDLE),
        .expired_o (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_TWB;
            S_TWB:   if (twb_done) state_d = use_pin_q ? S_PIN : S_POLL;
            S_PIN:   if (rb_s || expired) state_d = S_FINAL;
            S_POLL:  if (st_ack_i && (stat_ready(st_data_i) || expired))
                         state_d = S_FINAL;
            S_FINAL: if (st_ack_i) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_pin_q <= 1'b0;
            cmd_q     <= 1'b0;
            to_q      <= 1'b0;
            done_o    <= 1'b0;
            status_o  <= 8'h00;
            timeout_o <= 1'b0;
            warn_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    use_pin_q <= use_pin_i;
                    cmd_q     <= 1'b1;
                    to_q      <= 1'b0;
                end
                S_PIN: if (rb_s || expired) begin
                    to_q <= !rb_s;
                end
                S_POLL: if (st_ack_i) begin
                    cmd_q <= 1'b0;
                    if (!stat_ready(st_data_i) && expired) to_q <= 1'b1;
                end
                S_FINAL: if (st_ack_i) begin
                    status_o  <= st_data_i;
                    timeout_o <= to_q;
                    warn_o    <= !stat_ready(st_data_i);
                    done_o    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign st_req_o = (state_q == S_POLL) || (state_q == S_FINAL);
    assign st_cmd_o = cmd_q;

endmodule

// File: rtl/nrw_checker.sv
module nrw_checker #(
    parameter int TWB_CYC = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       st_req_o,
    input logic       st_cmd_o,
    input logic       st_ack_i,
    input logic       done_o,
    input logic [7:0] status_o,
    input logic       timeout_o,
    input logic       warn_o
);
    logic        ck_busy;
    logic [15:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_busy <= 1'b0;
            gap     <= '0;
        end else if (!ck_busy && start_i) begin
            ck_busy <= 1'b1;
            gap     <= '0;
        end else begin
            if (ck_busy && done_o) ck_busy <= 1'b0;
            if (gap != 16'hFFFF)   gap <= gap + 1'b1;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_req_o && !st_ack_i |=> st_req_o); // R9
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_req_o && !st_ack_i |=> $stable(st_cmd_o)); // R9
    AST_TWB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_req_o |-> gap >= 16'(TWB_CYC)); // R2
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o) && $stable(timeout_o) && $stable(warn_o)); // R7
    AST_WARN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> warn_o == !status_o[6]); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_busy |-> !st_req_o && !done_o); // R8

endmodule

bind nand_rdy_wait_mon nrw_checker #(.TWB_CYC(TWB_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .st_req_o  (st_req_o),
    .st_cmd_o  (st_cmd_o),
    .st_ack_i  (st_ack_i),
    .done_o    (done_o),
    .status_o  (status_o),
    .timeout_o (timeout_o),
    .warn_o    (warn_o)
);

// File: tb/nand_rdy_wait_mon_tb.sv
module nand_rdy_wait_mon_tb;
    localparam int CPM = 20;
    localparam int TMS = 10;
    localparam int TWB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, use_pin_i = 1'b0, rb_i = 1'b0;
    logic st_req_o, st_cmd_o, done_o, timeout_o, warn_o;
    logic st_ack_i = 1'b0;
    logic [7:0] st_data_i = 8'h00;
    logic [7:0] status_o;

    always #2 clk = ~clk;

    nand_rdy_wait_mon #(.CYC_PER_MS(CPM), .TIMEOUT_MS(TMS), .TWB_CYC(TWB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_pin_i(use_pin_i),
        .rb_i(rb_i), .st_req_o(st_req_o), .st_cmd_o(st_cmd_o),
        .st_ack_i(st_ack_i), .st_data_i(st_data_i), .done_o(done_o),
        .status_o(status_o), .timeout_o(timeout_o), .warn_o(warn_o)
    );

    typedef struct {
        logic [7:0] st;
        logic       to;
        logic       wn;
        int         nreq;
        int         ncmd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int dones = 0;
    int nreq = 0, ncmd = 0, first_lat = -1, start_cyc = 0;
    int rdy_after = 0;
    logic [7:0] good_b = 8'hE0, busy_b = 8'h80;
    logic prev_done = 1'b0;

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // byte reader model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && st_req_o) begin
                if (nreq == 0) first_lat = cyc - start_cyc;
                if (st_cmd_o) ncmd++;
                st_data_i = (nreq >= rdy_after) ? good_b : busy_b;
                nreq++;
                repeat (2) @(negedge clk);
                st_ack_i = 1'b1;
                @(negedge clk);
                st_ack_i = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done) chk("R7 done width", 1, 0);
            if (done_o) begin
                dones++;
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " status"}, int'(status_o), int'(e.st));
                    chk({e.tag, " timeout"}, int'(timeout_o), int'(e.to));
                    chk({"R6 ", e.tag, " warn"}, int'(warn_o), int'(e.wn));
                    if (e.nreq >= 0) chk({e.tag, " reads"}, nreq, e.nreq);
                    chk({e.tag, " cmd-flag reads"}, ncmd, e.ncmd);
                end
            end
            prev_done <= done_o;
        end
    end

    task automatic run_op(input string tag, input logic pin, input int rb_at,
                          input int ra, input logic [7:0] gb, input logic [7:0] bb,
                          input logic [7:0] est, input logic eto, input logic ewn,
                          input int enr, input int extra_start);
        exp_t e;
        int n = 0;
        int d0;
        logic [7:0] held;
        e.st = est; e.to = eto; e.wn = ewn; e.nreq = enr; e.ncmd = 1; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        nreq = 0; ncmd = 0; first_lat = -1;
        rdy_after = ra; good_b = gb; busy_b = bb;
        use_pin_i = pin;
        rb_i = (rb_at == 0);
        d0 = dones;
        start_i = 1'b1; start_cyc = cyc;
        while (dones == d0 && n < 5000) begin
            @(negedge clk);
            n++;
            start_i = (n == extra_start);
            if (rb_at >= 0 && n >= rb_at) rb_i = 1'b1;
        end
        start_i = 1'b0;
        if (!pin) chk({"R2 ", tag, " first request latency"}, first_lat, TWB + 1);
        else      chk({"R2 ", tag, " tWB respected"}, int'(first_lat >= TWB + 1), 1);
        held = status_o;
        d0 = dones;
        repeat (40) @(negedge clk);
        chk({"R7 ", tag, " status held"}, int'(status_o), int'(held));
        chk({"R8 ", tag, " no extra done"}, dones, d0);
        rb_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset req", int'(st_req_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset status", int'(status_o), 0);
        chk("R1 reset timeout", int'(timeout_o), 0);
        chk("R1 reset warn", int'(warn_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R3 pin rises late, good byte
        run_op("R3 pin normal", 1'b1, 40, 0, 8'hE0, 8'h80, 8'hE0, 1'b0, 1'b0, 1, 0);
        // R6 pin high at once but device busy
        run_op("R6 pin faulty", 1'b1, 0, 99, 8'hE0, 8'h81, 8'h81, 1'b0, 1'b1, 1, 0);
        // R5 pin never rises, busy byte
        run_op("R5 pin timeout", 1'b1, -1, 99, 8'hE0, 8'h80, 8'h80, 1'b1, 1'b1, 1, 0);
        // R5 pin never rises, final byte ready
        run_op("R5 pin timeout ready", 1'b1, -1, 0, 8'hC1, 8'h80, 8'hC1, 1'b1, 1'b0, 1, 0);
        // R5 boundary: pin rises before the limit
        run_op("R5 pin late ok", 1'b1, 150, 0, 8'hE0, 8'h80, 8'hE0, 1'b0, 1'b0, 1, 0);
        // R4 poll: ready after 3 polls, pin held high and ignored
        run_op("R4 poll three", 1'b0, 0, 3, 8'hE0, 8'h80, 8'hE0, 1'b0, 1'b0, 5, 0);
        // R4 poll: ready at first poll
        run_op("R4 poll immediate", 1'b0, -1, 0, 8'hE1, 8'h80, 8'hE1, 1'b0, 1'b0, 2, 0);
        // R5 poll never ready
        run_op("R5 poll timeout", 1'b0, -1, 100000, 8'hE0, 8'h80, 8'h80, 1'b1, 1'b1, -1, 0);
        // R8 second start mid-operation ignored
        run_op("R8 restart ignored", 1'b1, 40, 0, 8'hE0, 8'h80, 8'hE0, 1'b0, 1'b0, 1, 20);
        chk("R9 all expected results seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule